// File: doc/BRIEF.md
# Two-Dimensional Halfword Address Generator

This block emits one halfword address per accepted cycle for a rectangular transfer described by a start address, an element count per row, a step inside a row, a row count and a step applied after each row. Two identical generators, a source and a destination, run in lockstep, so one element is read and one is written per step. This serves a memory-to-memory copy of an image into a window of a frame buffer, and also a continuous frame-buffer read-out for a display.

In scan mode both generators walk the frame buffer with a 2-byte step inside and between rows. In blit mode a small arithmetic helper derives the destination parameters from the window position, the image size and the pixel size; the source walks the image contiguously. In autobuffer mode the generators reload their start addresses after the last element and carry on without a new start. Each generator is a two-state machine: `AG_IDLE` and `AG_RUN`. The transitions are *load* (AG_IDLE to AG_RUN on an accepted start), *row step* and *row wrap* (AG_RUN to itself inside a row and at a row end), *frame wrap* (AG_RUN to itself after the last element with autobuffer on), *finish* (AG_RUN to AG_IDLE after the last element with autobuffer off) and *abort* (AG_RUN to AG_IDLE on stop).

Top module: `dma2d_blit_agu`

## Requirements
- R1: After reset `valid_o`, `busy_o`, `done_o` and `err_o` are 0.
- R2: A `start_i` pulse while idle with non-zero counts makes `valid_o` and `busy_o` 1 from the next cycle, with the start addresses on `src_addr_o` and `dst_addr_o`; all parameters are captured at that edge and later input changes do not affect the running transfer.
- R3: An element is accepted in a cycle where `valid_o` is 1 and `stall_i` is 0; inside a row the next address is the current one plus 2, and with `stall_i` at 1 the addresses hold.
- R4: `row_last_o` is 1 exactly on the last element of each row; after that element is accepted the next address is the current one plus the row step of that channel.
- R5: In scan mode (`blit_i`=0) both channels start at `fb_base_i`, use `scan_xcnt_i` elements per row, `scan_ycnt_i` rows and a row step of 2.
- R6: In blit mode (`blit_i`=1) the destination starts at `fb_base_i` + (`win_x_i` with bit 0 forced to 0) × BPP + `win_y_i` × LINE_PIX × BPP, BPP (2 or 3) and LINE_PIX being parameters.
- R7: In blit mode both channels use floor(`img_w_i` × BPP / 2) elements per row and `img_h_i` rows; the destination row step is (LINE_PIX − `img_w_i`) × BPP + 2 and the source starts at `img_base_i` with a row step of 2.
- R8: With autobuffer off, after the last element of the last row is accepted `valid_o` and `busy_o` fall in the next cycle and `done_o` becomes 1.
- R9: With autobuffer on (captured at start), the element after the last one is again the start address, `busy_o` stays 1 and `done_o` is not set.
- R10: `clr_i` bit 0 clears `done_o` and bit 1 clears `err_o`, one cycle later; a flag being set in the same cycle as its clear stays 1.
- R11: A start while idle with a zero element count or zero row count sets `err_o` and does not begin a transfer.
- R12: `stop_i` while busy returns to idle in the next cycle without setting `done_o`; `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| stop_i | input | 1 | Abort the running transfer |
| autobuf_i | input | 1 | Repeat the pattern endlessly (captured at start) |
| blit_i | input | 1 | 1: window copy, 0: frame scan |
| stall_i | input | 1 | Hold the current element |
| clr_i | input | 2 | Write-one-to-clear: bit 0 done, bit 1 error |
| fb_base_i | input | AW | Frame buffer base address |
| img_base_i | input | AW | Image base address (blit source) |
| win_x_i | input | PW | Window column in pixels |
| win_y_i | input | PW | Window row in lines |
| img_w_i | input | PW | Image width in pixels |
| img_h_i | input | PW | Image height in lines |
| scan_xcnt_i | input | CW | Elements per row in scan mode |
| scan_ycnt_i | input | CW | Rows in scan mode |
| src_addr_o | output | AW | Source element address |
| dst_addr_o | output | AW | Destination element address |
| valid_o | output | 1 | Addresses are valid this cycle |
| row_last_o | output | 1 | Current element ends a row |
| busy_o | output | 1 | Run flag |
| done_o | output | 1 | Transfer complete flag |
| err_o | output | 1 | Bad-parameter flag |

## Verification
Completion of a transfer and a software clear of the done flag can land on the same edge; the bench holds the done-clear bit high for the whole of a short transfer so the last accepted element and the clear coincide, and expects the flag to read 1 the next cycle and 0 the cycle after. A stall can also coincide with a row end or the frame end, which a periodic stall pattern provokes; the behavioural queue model, which pops one expected address pair per accepted element, judges every cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [0:0] {
        AG_IDLE = 1'b0,
        AG_RUN  = 1'b1
    } ag_state_t;

endpackage

// File: rtl/dma2d_window_calc.sv
module dma2d_window_calc #(
    parameter int AW       = 32,
    parameter int CW       = 16,
    parameter int PW       = 10,
    parameter int BPP      = 2,
    parameter int LINE_PIX = 320
) (
    input  logic [AW-1:0] fb_base_i,
    input  logic [PW-1:0] win_x_i,
    input  logic [PW-1:0] win_y_i,
    input  logic [PW-1:0] img_w_i,
    input  logic [PW-1:0] img_h_i,
    output logic [AW-1:0] dst_start_o,
    output logic [CW-1:0] xcnt_o,
    output logic [CW-1:0] ycnt_o,
    output logic [AW-1:0] dst_ymod_o
);
    localparam int LINE_BYTES = LINE_PIX * BPP;

    logic [AW-1:0] even_x;
    logic [AW-1:0] row_bytes;

    // column is rounded down to an even pixel so a halfword pair never splits
    assign even_x      = AW'({win_x_i[PW-1:1], 1'b0});
    assign row_bytes   = AW'(img_w_i) * AW'(BPP);
    assign dst_start_o = fb_base_i + even_x * AW'(BPP) + AW'(win_y_i) * AW'(LINE_BYTES);
    assign xcnt_o      = CW'(row_bytes >> 1);
    assign ycnt_o      = CW'(img_h_i);
    assign dst_ymod_o  = AW'(LINE_BYTES) - row_bytes + AW'(2);

endmodule

// File: rtl/dma2d_agu_core.sv
module dma2d_agu_core
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          abort_i,
    input  logic          step_i,
    input  logic          autobuf_i,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] xmod_i,
    input  logic [AW-1:0] ymod_i,
    input  logic [CW-1:0] xcnt_i,
    input  logic [CW-1:0] ycnt_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o,
    output logic          row_last_o,
    output logic          frame_last_o,
    output logic          fin_o
);
    ag_state_t     state_q, state_d;
    logic [AW-1:0] addr_q, start_q, xmod_q, ymod_q;
    logic [CW-1:0] xleft_q, yleft_q, xcnt_q, ycnt_q;
    logic          auto_q;
    logic          take;

    assign take = (state_q == AG_RUN) && step_i && !abort_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AG_IDLE;
        else        state_q <= state_d;
    end

    // transitions: load, finish, abort (row step / row wrap / frame wrap stay in AG_RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AG_IDLE: if (load_i) state_d = AG_RUN;
            AG_RUN: begin
                if (abort_i)                                state_d = AG_IDLE;
                else if (take && frame_last_o && !auto_q)   state_d = AG_IDLE;
            end
            default: state_d = AG_IDLE;
        endcase
    end

    // address and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            start_q <= '0;
            xmod_q  <= '0;
            ymod_q  <= '0;
            xcnt_q  <= '0;
            ycnt_q  <= '0;
            xleft_q <= '0;
            yleft_q <= '0;
            auto_q  <= 1'b0;
        end else if (state_q == AG_IDLE) begin
            if (load_i) begin
                addr_q  <= start_i;
                start_q <= start_i;
                xmod_q  <= xmod_i;
                ymod_q  <= ymod_i;
                xcnt_q  <= xcnt_i;
                ycnt_q  <= ycnt_i;
                xleft_q <= xcnt_i;
                yleft_q <= ycnt_i;
                auto_q  <= autobuf_i;
            end
        end else if (take) begin
            if (xleft_q == CW'(1)) begin
                xleft_q <= xcnt_q;
                if (yleft_q == CW'(1)) begin
                    addr_q  <= start_q;      // frame wrap
                    yleft_q <= ycnt_q;
                end else begin
                    addr_q  <= addr_q + ymod_q;  // row wrap
                    yleft_q <= yleft_q - CW'(1);
                end
            end else begin
                addr_q  <= addr_q + xmod_q;      // row step
                xleft_q <= xleft_q - CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        addr_o       = addr_q;
        valid_o      = (state_q == AG_RUN);
        row_last_o   = valid_o && (xleft_q == CW'(1));
        frame_last_o = row_last_o && (yleft_q == CW'(1));
        fin_o        = take && frame_last_o && !auto_q;
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !step_i && !abort_i) |=> (valid_o && $stable(addr_o))); // R3

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !row_last_o) |=> (addr_o == $past(addr_o) + $past(xmod_q))); // R3

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && row_last_o && !frame_last_o) |=> (addr_o == $past(addr_o) + $past(ymod_q))); // R4

    AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && frame_last_o && auto_q) |=> (valid_o && addr_o == $past(start_q))); // R9

endmodule

// File: rtl/dma2d_blit_agu.sv
module dma2d_blit_agu #(
    parameter int AW       = 32,
    parameter int CW       = 16,
    parameter int PW       = 10,
    parameter int BPP      = 2,
    parameter int LINE_PIX = 320
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          autobuf_i,
    input  logic          blit_i,
    input  logic          stall_i,
    input  logic [1:0]    clr_i,
    input  logic [AW-1:0] fb_base_i,
    input  logic [AW-1:0] img_base_i,
    input  logic [PW-1:0] win_x_i,
    input  logic [PW-1:0] win_y_i,
    input  logic [PW-1:0] img_w_i,
    input  logic [PW-1:0] img_h_i,
    input  logic [CW-1:0] scan_xcnt_i,
    input  logic [CW-1:0] scan_ycnt_i,
    output logic [AW-1:0] src_addr_o,
    output logic [AW-1:0] dst_addr_o,
    output logic          valid_o,
    output logic          row_last_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam logic [AW-1:0] HALF_STEP = AW'(2);

    logic [AW-1:0] win_start, win_ymod;
    logic [CW-1:0] win_xcnt, win_ycnt;

    logic [AW-1:0] src_start, dst_start, dst_ymod;
    logic [CW-1:0] xcnt, ycnt;
    logic          cfg_ok, load, err_set;
    logic          src_valid, src_rl, src_fl, src_fin;
    logic          dst_valid, dst_rl, dst_fl, dst_fin;
    logic          done_q, err_q;

    dma2d_window_calc #(
        .AW(AW), .CW(CW), .PW(PW), .BPP(BPP), .LINE_PIX(LINE_PIX)
    ) u_win (
        .fb_base_i  (fb_base_i),
        .win_x_i    (win_x_i),
        .win_y_i    (win_y_i),
        .img_w_i    (img_w_i),
        .img_h_i    (img_h_i),
        .dst_start_o(win_start),
        .xcnt_o     (win_xcnt),
        .ycnt_o     (win_ycnt),
        .dst_ymod_o (win_ymod)
    );

    always_comb begin
        if (blit_i) begin
            src_start = img_base_i;
            dst_start = win_start;
            dst_ymod  = win_ymod;
            xcnt      = win_xcnt;
            ycnt      = win_ycnt;
        end else begin
            src_start = fb_base_i;
            dst_start = fb_base_i;
            dst_ymod  = HALF_STEP;
            xcnt      = scan_xcnt_i;
            ycnt      = scan_ycnt_i;
        end
    end

    assign cfg_ok  = (xcnt != '0) && (ycnt != '0);
    assign load    = start_i && !busy_o && cfg_ok;
    assign err_set = start_i && !busy_o && !cfg_ok;

    dma2d_agu_core #(.AW(AW), .CW(CW)) u_src (
        .clk(clk), .rst_n(rst_n), .load_i(load), .abort_i(stop_i), .step_i(!stall_i),
        .autobuf_i(autobuf_i), .start_i(src_start), .xmod_i(HALF_STEP), .ymod_i(HALF_STEP),
        .xcnt_i(xcnt), .ycnt_i(ycnt), .addr_o(src_addr_o), .valid_o(src_valid),
        .row_last_o(src_rl), .frame_last_o(src_fl), .fin_o(src_fin)
    );

    dma2d_agu_core #(.AW(AW), .CW(CW)) u_dst (
        .clk(clk), .rst_n(rst_n), .load_i(load), .abort_i(stop_i), .step_i(!stall_i),
        .autobuf_i(autobuf_i), .start_i(dst_start), .xmod_i(HALF_STEP), .ymod_i(dst_ymod),
        .xcnt_i(xcnt), .ycnt_i(ycnt), .addr_o(dst_addr_o), .valid_o(dst_valid),
        .row_last_o(dst_rl), .frame_last_o(dst_fl), .fin_o(dst_fin)
    );

    // status flags: a set in the same cycle as its clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= dst_fin | (done_q & ~clr_i[0]);
            err_q  <= err_set | (err_q & ~clr_i[1]);
        end
    end

    always_comb begin
        valid_o    = dst_valid;
        row_last_o = dst_rl;
        busy_o     = dst_valid;
        done_o     = done_q;
        err_o      = err_q;
    end

    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid == dst_valid) && (src_rl == dst_rl) && (src_fl == dst_fl) && (src_fin == dst_fin)); // R2

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy_o); // R2

    AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dst_fin |=> (done_o && !busy_o)); // R8

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[0] && !dst_fin) |=> !done_o); // R10

    AST_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> (err_o && !busy_o)); // R11

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stop_i) |=> (!busy_o && !$rose(done_o))); // R12

endmodule

// File: tb/tb_dma2d_blit_agu.sv
`timescale 1ns/1ps
module tb_dma2d_blit_agu;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int PW = 10;
    localparam int BPP = 3;
    localparam int LP = 320;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, autobuf_i = 0, blit_i = 0, stall_i = 0;
    logic [1:0] clr_i = '0;
    logic [AW-1:0] fb_base_i = '0, img_base_i = '0;
    logic [PW-1:0] win_x_i = '0, win_y_i = '0, img_w_i = '0, img_h_i = '0;
    logic [CW-1:0] scan_xcnt_i = '0, scan_ycnt_i = '0;
    logic [AW-1:0] src_addr_o, dst_addr_o;
    logic valid_o, row_last_o, busy_o, done_o, err_o;

    always #2.5 clk = ~clk;

    dma2d_blit_agu #(.AW(AW), .CW(CW), .PW(PW), .BPP(BPP), .LINE_PIX(LP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .autobuf_i(autobuf_i),
        .blit_i(blit_i), .stall_i(stall_i), .clr_i(clr_i), .fb_base_i(fb_base_i),
        .img_base_i(img_base_i), .win_x_i(win_x_i), .win_y_i(win_y_i), .img_w_i(img_w_i),
        .img_h_i(img_h_i), .scan_xcnt_i(scan_xcnt_i), .scan_ycnt_i(scan_ycnt_i),
        .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .valid_o(valid_o),
        .row_last_o(row_last_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    string sc_tag = "R1";
    bit stall_en = 0;

    // behavioural model
    bit m_run = 0, m_auto = 0, m_done = 0, m_err = 0;
    logic [31:0] m_s0, m_d0, m_sym, m_dym;
    int m_xc, m_yc;
    logic [31:0] q_s[$];
    logic [31:0] q_d[$];
    bit q_r[$];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", sc_tag, what, act, exp, cyc);
        end
    endtask

    task automatic build_q();
        logic [31:0] s, d;
        q_s.delete(); q_d.delete(); q_r.delete();
        s = m_s0; d = m_d0;
        for (int r = 0; r < m_yc; r++) begin
            for (int c = 0; c < m_xc; c++) begin
                q_s.push_back(s); q_d.push_back(d); q_r.push_back(c == m_xc - 1);
                if (c == m_xc - 1) begin s = s + m_sym; d = d + m_dym; end
                else begin s = s + 32'd2; d = d + 32'd2; end
            end
        end
    endtask

    always @(posedge clk) begin
        bit sd, se;
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_auto = 0; m_done = 0; m_err = 0;
            q_s.delete(); q_d.delete(); q_r.delete();
        end else begin
            sd = 0; se = 0;
            if (m_run) begin
                if (stop_i) begin
                    m_run = 0;
                    q_s.delete(); q_d.delete(); q_r.delete();
                end else if (!stall_i) begin
                    void'(q_s.pop_front()); void'(q_d.pop_front()); void'(q_r.pop_front());
                    if (q_s.size() == 0) begin
                        if (m_auto) build_q();
                        else begin m_run = 0; sd = 1; end
                    end
                end
            end else if (start_i) begin
                if (blit_i) begin
                    int w, h, wx, wy;
                    w = int'(img_w_i); h = int'(img_h_i); wx = int'(win_x_i); wy = int'(win_y_i);
                    m_s0  = img_base_i;
                    m_d0  = fb_base_i + 32'((wx / 2) * 2 * BPP + wy * LP * BPP);
                    m_xc  = (w * BPP) / 2;
                    m_yc  = h;
                    m_sym = 32'd2;
                    m_dym = 32'((LP - w) * BPP + 2);
                end else begin
                    m_s0 = fb_base_i; m_d0 = fb_base_i;
                    m_xc = int'(scan_xcnt_i); m_yc = int'(scan_ycnt_i);
                    m_sym = 32'd2; m_dym = 32'd2;
                end
                if (m_xc == 0 || m_yc == 0) se = 1;
                else begin build_q(); m_run = 1; m_auto = autobuf_i; end
            end
            m_done = sd | (m_done & !clr_i[0]);
            m_err  = se | (m_err & !clr_i[1]);
        end
        if (cyc == 20000) begin
            fails++; tests++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(valid_o == m_run, "valid_o", 32'(valid_o), 32'(m_run));
            chk(busy_o == m_run, "busy_o", 32'(busy_o), 32'(m_run));
            chk(done_o == m_done, "done_o", 32'(done_o), 32'(m_done));
            chk(err_o == m_err, "err_o", 32'(err_o), 32'(m_err));
            if (m_run && q_s.size() > 0) begin
                chk(src_addr_o == q_s[0], "src_addr_o", src_addr_o, q_s[0]);
                chk(dst_addr_o == q_d[0], "dst_addr_o", dst_addr_o, q_d[0]);
                chk(row_last_o == q_r[0], "row_last_o", 32'(row_last_o), 32'(q_r[0]));
            end
        end
    end

    always @(negedge clk) stall_i <= stall_en && (cyc % 3 == 1);

    task automatic wait_idle();
        do @(negedge clk); while (m_run);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        sc_tag = "R1";
        chk(!valid_o && !busy_o, "reset run R1", 32'(busy_o), 0);
        chk(!done_o && !err_o, "reset flags R1", 32'({done_o, err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // scan, stalls, parameters changed and restart attempted mid-run
        sc_tag = "R2 R3 R4 R5 R8 R12";
        stall_en = 1; blit_i = 0; autobuf_i = 0;
        fb_base_i = 32'h1000; scan_xcnt_i = 3; scan_ycnt_i = 2;
        start_i = 1; @(negedge clk); start_i = 0;
        @(negedge clk);
        fb_base_i = 32'h9000; scan_xcnt_i = 7; start_i = 1;
        @(negedge clk); start_i = 0;
        wait_idle();

        // done set and cleared on the same edge
        sc_tag = "R10 R8";
        stall_en = 0; fb_base_i = 32'h2000; scan_xcnt_i = 2; scan_ycnt_i = 1;
        clr_i = 2'b01;
        start_i = 1; @(negedge clk); start_i = 0;
        wait_idle();
        clr_i = 2'b00;

        // window copy, odd column, with stalls
        sc_tag = "R6 R7 R3 R4";
        stall_en = 1; blit_i = 1;
        fb_base_i = 32'h4000; img_base_i = 32'h200;
        win_x_i = 7; win_y_i = 5; img_w_i = 4; img_h_i = 3;
        start_i = 1; @(negedge clk); start_i = 0;
        wait_idle();

        // window copy, odd row byte count
        sc_tag = "R6 R7";
        stall_en = 0; win_x_i = 4; win_y_i = 1; img_w_i = 5; img_h_i = 2;
        clr_i = 2'b01; @(negedge clk); clr_i = 2'b00;
        start_i = 1; @(negedge clk); start_i = 0;
        wait_idle();

        // autobuffer repeat, then stop
        sc_tag = "R9 R12";
        stall_en = 1; blit_i = 0; autobuf_i = 1;
        fb_base_i = 32'h3000; scan_xcnt_i = 2; scan_ycnt_i = 2;
        start_i = 1; @(negedge clk); start_i = 0; autobuf_i = 0;
        repeat (20) @(negedge clk);
        stop_i = 1; @(negedge clk); stop_i = 0;
        repeat (3) @(negedge clk);
        chk(!busy_o, "idle after stop R12", 32'(busy_o), 0);

        // bad parameters
        sc_tag = "R11";
        stall_en = 0; scan_ycnt_i = 0;
        start_i = 1; @(negedge clk); start_i = 0;
        repeat (2) @(negedge clk);
        chk(err_o && !busy_o, "zero rows R11", 32'({err_o, busy_o}), 32'b10);
        sc_tag = "R10 R11";
        clr_i = 2'b10; @(negedge clk); clr_i = 2'b00;
        blit_i = 1; img_w_i = 0; img_h_i = 3;
        start_i = 1; @(negedge clk); start_i = 0;
        repeat (3) @(negedge clk);
        clr_i = 2'b10; @(negedge clk); clr_i = 2'b00;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule